// File: doc/BRIEF.md
# Dual-Host Mailbox Status Controller

This block lets two microcontrollers that share one byte-wide register port exchange bytes through three 8-bit mailbox registers. When either host writes a mailbox, a per-mailbox change flag rises in a read-only status byte. The other host polls that byte or takes an interrupt, reads the mailbox, and the read clears that flag. The writer can then watch the flag drop and knows its byte has been consumed.

The same status byte also reports events from the surrounding chip. Two bits follow their inputs live: PLL lock and motor overflow. Two bits are latched: FIFO overflow and header-valid. A byte-wide interrupt-enable register masks the status byte, and an active-low interrupt line is asserted while any enabled status bit is 1.

A build parameter selects an identification variant. In that variant bit 1 of the third mailbox always reads back as 0, so software can tell the two builds apart by writing and reading that mailbox.

Top module: `mbox_status_ctrl`

## Requirements
- R1: Mailboxes one, two and three sit at addresses 0x08, 0x09 and 0x0A. A write stores the byte at the clock edge, and a read returns it combinationally in the same cycle.
- R2: With ID_QUIRK=1, bit 1 of the mailbox at 0x0A always reads 0. With ID_QUIRK=0 it reads the last value written.
- R3: A write to a mailbox sets its change flag in the status byte at 0x0B (bit 7 for 0x08, bit 6 for 0x09, bit 5 for 0x0A). This happens even when the byte written equals the stored one.
- R4: A read of a mailbox clears its own change flag. If the same mailbox is written and read in one cycle, the flag ends up set.
- R5: Status bit 4 equals the PLL-lock input and status bit 2 equals the motor-overflow input in the same cycle, with no latching.
- R6: Status bit 1 is set by a FIFO-overflow event pulse and stays set. A read of the status byte clears it, unless a new event arrives in that same cycle.
- R7: Status bit 3 is set by a new-header pulse. A read of address 0x0D clears it, unless a new pulse arrives in that same cycle.
- R8: The interrupt-enable register at 0x0C is read/write. irq_n is 0 while any status bit and its enable bit are both 1, and 1 otherwise.
- R9: After reset, all mailboxes, flags and enables are 0 and irq_n is 1.
- R10: A read of an unmapped address returns 0x00 and changes no flag. Status bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; read side effects apply at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for the addressed register |
| pll_lock_i | input | 1 | Live PLL-lock level |
| motor_ovf_i | input | 1 | Live motor-overflow level |
| fifo_ovf_evt_i | input | 1 | FIFO-overflow event pulse |
| hdr_new_i | input | 1 | New header/subcode available pulse |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two pairs of functions can act on the same flag in the same cycle. The first pair is a mailbox write and a read of that same mailbox. The bench drives both strobes with one address and then expects the change flag to be set. The second pair is a clearing read and a new event. The bench reads the status byte while pulsing the FIFO-overflow event, and reads address 0x0D while pulsing the new-header input. In each case it reads the status byte afterwards and expects the event bit to stay set.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MBOX_CNT      = 3;
    localparam int MBOX_BASE     = 8'h08;
    localparam int STAT_ADDR     = 8'h0B;
    localparam int IEN_ADDR      = 8'h0C;
    localparam int HDR_END_ADDR  = 8'h0D;

    // status bit positions (decoded by software)
    localparam int ST_CHG_TOP    = 7;   // mailbox k change flag at ST_CHG_TOP-k
    localparam int ST_PLL        = 4;
    localparam int ST_HDR        = 3;
    localparam int ST_MOTOR      = 2;
    localparam int ST_FIFO       = 1;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
    parameter int DATA_W     = 8,
    parameter bit CLEAR_BIT1 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              changed
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        CLEAR_BIT1 ? ~(DATA_W'(2)) : {DATA_W{1'b1}};

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              chg;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (rd_hit) slot_d.chg = 1'b0;
        if (wr_hit) begin
            slot_d.val = wdata & KEEP_MASK;
            slot_d.chg = 1'b1;          // write wins over a same-cycle read
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign value   = slot_q.val;
    assign changed = slot_q.chg;
endmodule

// File: rtl/mbox_sticky.sv
module mbox_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req) st_d.flag = 1'b0;
        if (set_evt) st_d.flag = 1'b1;  // new event beats the clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/mbox_status_ctrl.sv
module mbox_status_ctrl #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter bit ID_QUIRK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pll_lock_i,
    input  logic              motor_ovf_i,
    input  logic              fifo_ovf_evt_i,
    input  logic              hdr_new_i,
    output logic              irq_n
);
    import mbox_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);
    localparam logic [ADDR_W-1:0] A_HEND = ADDR_W'(HDR_END_ADDR);

    logic [MBOX_CNT-1:0]   mb_wr, mb_rd, mb_chg;
    logic [DATA_W-1:0]     mb_val [MBOX_CNT];
    logic                  fifo_flag, hdr_flag;
    logic [DATA_W-1:0]     status_w;

    genvar k;
    generate
        for (k = 0; k < MBOX_CNT; k++) begin : g_mbox
            localparam logic [ADDR_W-1:0] A_MB = ADDR_W'(MBOX_BASE + k);
            assign mb_wr[k] = wr_en && (addr == A_MB);
            assign mb_rd[k] = rd_en && (addr == A_MB);
            mbox_slot #(
                .DATA_W    (DATA_W),
                .CLEAR_BIT1(ID_QUIRK && (k == MBOX_CNT - 1))
            ) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (mb_wr[k]),
                .rd_hit (mb_rd[k]),
                .wdata  (wdata),
                .value  (mb_val[k]),
                .changed(mb_chg[k])
            );
        end
    endgenerate

    mbox_sticky u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(fifo_ovf_evt_i),
        .clr_req(rd_en && (addr == A_STAT)),
        .flag   (fifo_flag)
    );

    mbox_sticky u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(hdr_new_i),
        .clr_req(rd_en && (addr == A_HEND)),
        .flag   (hdr_flag)
    );

    // interrupt-enable register, two-process
    typedef struct packed {
        logic [DATA_W-1:0] ien;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && (addr == A_IEN)) ctl_d.ien = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        status_w = '0;
        for (int i = 0; i < MBOX_CNT; i++) status_w[ST_CHG_TOP - i] = mb_chg[i];
        status_w[ST_PLL]   = pll_lock_i;
        status_w[ST_HDR]   = hdr_flag;
        status_w[ST_MOTOR] = motor_ovf_i;
        status_w[ST_FIFO]  = fifo_flag;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_STAT)      rdata = status_w;
        else if (addr == A_IEN)  rdata = ctl_q.ien;
        for (int i = 0; i < MBOX_CNT; i++)
            if (addr == ADDR_W'(MBOX_BASE + i)) rdata = mb_val[i];
    end

    assign irq_n = ~|(status_w & ctl_q.ien);
endmodule

// File: rtl/mbox_status_chk.sv
module mbox_status_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter bit ID_QUIRK = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              pll_lock_i,
    input logic              motor_ovf_i,
    input logic              fifo_ovf_evt_i,
    input logic              hdr_new_i,
    input logic [DATA_W-1:0] status,
    input logic              irq_n
);
    assert_chg_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h08)) |=> status[7]);

    assert_chg_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(8'h09)) |=> !status[6]);

    assert_live_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] == pll_lock_i) && (status[2] == motor_ovf_i));

    assert_fifo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf_evt_i |=> status[1]);

    assert_hdr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_new_i |=> status[3]);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> irq_n);

    assert_id_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ID_QUIRK && addr == ADDR_W'(8'h0A)) |-> !rdata[1]);

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADDR_W'(8'h0C)) |-> (rdata == '0));
endmodule

bind mbox_status_ctrl mbox_status_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ID_QUIRK(ID_QUIRK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .rdata         (rdata),
    .pll_lock_i    (pll_lock_i),
    .motor_ovf_i   (motor_ovf_i),
    .fifo_ovf_evt_i(fifo_ovf_evt_i),
    .hdr_new_i     (hdr_new_i),
    .status        (status_w),
    .irq_n         (irq_n)
);

// File: tb/sim_mbox_status_ctrl.sv
`timescale 1ns/1ps
module sim_mbox_status_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, rdata1;
    logic       pll = 1'b0, motor = 1'b0, fevt = 1'b0, hnew = 1'b0;
    logic       irq_n, irq_n1;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mbox_status_ctrl #(.ID_QUIRK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pll_lock_i(pll), .motor_ovf_i(motor),
        .fifo_ovf_evt_i(fevt), .hdr_new_i(hnew), .irq_n(irq_n));

    mbox_status_ctrl #(.ID_QUIRK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata1), .pll_lock_i(pll), .motor_ovf_i(motor),
        .fifo_ovf_evt_i(fevt), .hdr_new_i(hnew), .irq_n(irq_n1));

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // one read cycle; the side effect applies at the following posedge
    task automatic bus_read(logic [7:0] a, output logic [7:0] d, output logic [7:0] d1);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1; d = rdata; d1 = rdata1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] s);
        @(negedge clk); addr = 8'h0B; rd_en = 1'b0;
        #1; s = rdata;
    endtask

    task automatic clear_mailboxes();
        logic [7:0] d, d1;
        for (int i = 0; i < 3; i++) bus_read(8'h08 + 8'(i), d, d1);
    endtask

    task automatic t_reset();
        logic [7:0] d, d1;
        peek_status(d);
        check("R9 status", d, 8'h00);
        check("R9 irq_n", {7'd0, irq_n}, 8'h01);
        bus_read(8'h08, d, d1); check("R9 mailbox1", d, 8'h00);
        bus_read(8'h0C, d, d1); check("R9 enable", d, 8'h00);
    endtask

    task automatic t_mailbox();
        logic [7:0] d, d1;
        bus_write(8'h08, 8'hA5);
        bus_write(8'h09, 8'h3C);
        bus_write(8'h0A, 8'hFF);
        peek_status(d);  check("R3 flags", d, 8'hE0);
        bus_read(8'h08, d, d1); check("R1 mailbox1", d, 8'hA5);
        bus_read(8'h09, d, d1); check("R1 mailbox2", d, 8'h3C);
        bus_read(8'h0A, d, d1);
        check("R2 quirk bit1", d, 8'hFD);
        check("R2 no quirk", d1, 8'hFF);
        peek_status(d);  check("R4 flags cleared", d, 8'h00);
        bus_write(8'h09, 8'h3C);
        peek_status(d);  check("R3 same value", d, 8'h40);
        clear_mailboxes();
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk); addr = 8'h08; wdata = 8'h11; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        peek_status(d); check("R4 write beats read", d, 8'h80);
        clear_mailboxes();
        peek_status(d); check("R4 cleared", d, 8'h00);
    endtask

    task automatic t_live();
        logic [7:0] d;
        @(negedge clk); pll = 1'b1;
        peek_status(d); check("R5 pll", d, 8'h10);
        @(negedge clk); pll = 1'b0; motor = 1'b1;
        peek_status(d); check("R5 motor", d, 8'h04);
        @(negedge clk); motor = 1'b0;
        peek_status(d); check("R5 idle", d, 8'h00);
    endtask

    task automatic t_fifo();
        logic [7:0] d, d1;
        @(negedge clk); fevt = 1'b1;
        @(negedge clk); fevt = 1'b0;
        repeat (3) @(negedge clk);
        peek_status(d); check("R6 sticky", d, 8'h02);
        bus_read(8'h0B, d, d1); check("R6 read shows", d, 8'h02);
        peek_status(d); check("R6 cleared", d, 8'h00);
        @(negedge clk); fevt = 1'b1;
        @(negedge clk); fevt = 1'b0;
        @(negedge clk); addr = 8'h0B; rd_en = 1'b1; fevt = 1'b1;
        @(negedge clk); rd_en = 1'b0; fevt = 1'b0;
        peek_status(d); check("R6 event beats clear", d, 8'h02);
        bus_read(8'h0B, d, d1);
    endtask

    task automatic t_header();
        logic [7:0] d, d1;
        @(negedge clk); hnew = 1'b1;
        @(negedge clk); hnew = 1'b0;
        peek_status(d); check("R7 set", d, 8'h08);
        bus_read(8'h0D, d, d1);
        peek_status(d); check("R7 cleared", d, 8'h00);
        @(negedge clk); hnew = 1'b1;
        @(negedge clk); addr = 8'h0D; rd_en = 1'b1; hnew = 1'b1;
        @(negedge clk); rd_en = 1'b0; hnew = 1'b0;
        peek_status(d); check("R7 pulse beats clear", d, 8'h08);
        bus_read(8'h0D, d, d1);
    endtask

    task automatic t_irq();
        logic [7:0] d, d1;
        bus_write(8'h0C, 8'h10);
        bus_read(8'h0C, d, d1); check("R8 enable readback", d, 8'h10);
        check("R8 irq idle", {7'd0, irq_n}, 8'h01);
        @(negedge clk); pll = 1'b1; #1;
        check("R8 irq on", {7'd0, irq_n}, 8'h00);
        @(negedge clk); pll = 1'b0; #1;
        check("R8 irq off", {7'd0, irq_n}, 8'h01);
        bus_write(8'h0C, 8'h20);
        bus_write(8'h0A, 8'h01); #1;
        check("R8 mailbox3 irq", {7'd0, irq_n}, 8'h00);
        bus_read(8'h0A, d, d1); #1;
        check("R8 irq after read", {7'd0, irq_n}, 8'h01);
        bus_write(8'h0C, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d, d1;
        bus_write(8'h08, 8'h77);
        @(negedge clk); fevt = 1'b1;
        @(negedge clk); fevt = 1'b0;
        bus_read(8'h20, d, d1); check("R10 unmapped data", d, 8'h00);
        bus_read(8'h07, d, d1); check("R10 below map", d, 8'h00);
        peek_status(d); check("R10 no side effect", d, 8'h82);
        check("R10 bit0", {7'd0, d[0]}, 8'h00);
        bus_read(8'h0B, d, d1);
        clear_mailboxes();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mailbox();
        t_collide();
        t_live();
        t_fifo();
        t_header();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule